// File: doc/BRIEF.md
# Add-in Card Slot Power and Reset Sequencer

This block brings an add-in card slot up and takes it down in an orderly way. When software or a parent controller asks for power-up, the sequencer turns on the slot's supplies and reference clock one at a time. It waits for each to report good before moving on, enables link training, and finally releases the active-low card reset. Release is held back until minimum gaps have elapsed, measured separately from main-supply-good and from clock-stable. After the link reports up, it waits a settling interval and then raises a ready flag.

A power-down request runs the reverse path:
1. Ask the card to enter its low-power state and wait for its acknowledge.
2. Assert card reset.
3. Drop main power.
4. Stop the reference clock.

A surprise power-loss input pulls card reset low through a purely combinational path, with no clock edge in between, and sends the controller to its error state. Every wait for an input has a timeout. A timeout parks the block in an error state with everything off until a new power-up request arrives. All intervals are parameters counted in clock cycles, and the counters are sized for the longest of them.

Top module: `slot_power_sequencer`

## Requirements
- R1: Card reset (`cardRstN`) is low out of reset and stays low whenever any of auxiliary enable, main enable or reference clock enable is low. It is released only after all of them are on.
- R2: Bring-up order is fixed: `auxEn` rises first. `mainEn` rises only after `auxGood` is seen, and `refClkEn` rises only after `mainGood` is seen.
- R3: At least `GAP_MAIN_CYC` cycles pass between the cycle `mainGood` is first seen and the rise of `cardRstN`.
- R4: At least `GAP_CLK_CYC` cycles pass between the cycle `clkStable` is first seen and the rise of `cardRstN`.
- R5: `trainEn` is high whenever `cardRstN` is high. With `EARLY_TRAIN`=1 it rises together with `auxEn`; with 0 it rises after the clock is stable. The release timing is the same for both settings.
- R6: The link-up source is `dllActive` when `dllCapable` is 1, and `vendorLinkUp` when `dllCapable` is 0; the other input is ignored. `ready` rises no sooner than `SETTLE_CYC` cycles after the selected source goes high.
- R7: A `downReq` pulse while `ready` is high runs the power-down path:
  - `lowPwrReq` is raised until `lowPwrAck` arrives.
  - `cardRstN` falls a cycle before `mainEn` falls.
  - `mainEn` falls a cycle before `refClkEn` falls.
  - `auxEn` goes low last, and the block returns to idle.
- R8: While `powerLoss` is high, `cardRstN` is low in the same cycle, without waiting for a clock edge. A power loss during any active state moves the block to error, with all enables off and `errFlag` high.
- R9: A wait on `auxGood`, `mainGood`, `clkStable`, link-up or `lowPwrAck` that lasts longer than `WAIT_TO_CYC` cycles enters error. In error, all enables are off, `cardRstN` is low, and `errFlag` stays high until the next `upReq`.
- R10: An `upReq` with `cardPresent` low leaves the block idle (or clears error into idle): all enables off, `cardRstN` low, `errFlag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReq | input | 1 | Power-up request pulse |
| downReq | input | 1 | Power-down request pulse |
| cardPresent | input | 1 | Card physically present in slot |
| auxGood | input | 1 | Auxiliary supply stable |
| mainGood | input | 1 | Main supply stable |
| clkStable | input | 1 | Reference clock stable |
| dllCapable | input | 1 | Standard link-active indication is supported |
| dllActive | input | 1 | Standard data-link-layer-active indication |
| vendorLinkUp | input | 1 | Controller-specific link-up status |
| lowPwrAck | input | 1 | Card acknowledges low-power state |
| powerLoss | input | 1 | Surprise power-loss alarm |
| auxEn | output | 1 | Auxiliary supply enable |
| mainEn | output | 1 | Main supply enable |
| refClkEn | output | 1 | Reference clock enable |
| trainEn | output | 1 | Link training enable |
| cardRstN | output | 1 | Active-low card reset |
| lowPwrReq | output | 1 | Request card low-power state |
| ready | output | 1 | Slot up and settled |
| errFlag | output | 1 | Sticky error (timeout or power loss) |

## Verification
The hardest situations to reach are the two independent gap windows at release. Each constrains the release only when its own stable input arrives late relative to the other. The stimulus therefore draws the supply, clock, link and acknowledge latencies at random per run, so that in some runs the main-supply gap decides the release and in others the clock gap does.

The bench also alternates the link-source selection and holds the ignored source high as a decoy. Error paths are reached by making one model input never answer, once in bring-up and once in power-down, and by a power-loss pulse placed between clock edges while the slot is ready.

// File: rtl/slot_seq_pkg.sv
`timescale 1ns/1ps
package slot_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_AUX, S_MAIN, S_CLK, S_GAP, S_LINK, S_SETTLE, S_READY,
    S_LPWAIT, S_DNRST, S_DNMAIN, S_DNCLK, S_ERR
  } seqState_t;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic clrClk;   // restart clock-stable age counter
    logic clrMain;  // restart main-stable age counter
    logic clrTmr;   // restart state wait timer
  } dpCtl_t;

endpackage

// File: rtl/slot_seq_timers.sv
`timescale 1ns/1ps
module slot_seq_timers
  import slot_seq_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int GAP_MAIN = 40,
  parameter int GAP_CLK  = 12,
  parameter int SETTLE   = 30,
  parameter int WAIT_TO  = 60
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  output logic   mainGapDone,
  output logic   clkGapDone,
  output logic   settleDone,
  output logic   waitExpired
);
  localparam int NCNT = 3;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [NCNT-1:0]       clrVec;
  logic [NCNT*CNT_W-1:0] cntFlat;

  assign clrVec = ctl;

  // index 0: wait timer, 1: main-stable age, 2: clock-stable age
  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            cnt <= '0;
      else if (clrVec[i])   cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end
    assign cntFlat[i*CNT_W +: CNT_W] = cnt;
  end

  logic [CNT_W-1:0] tmr, mainAge, clkAge;
  assign tmr     = cntFlat[0 +: CNT_W];
  assign mainAge = cntFlat[CNT_W +: CNT_W];
  assign clkAge  = cntFlat[2*CNT_W +: CNT_W];

  assign mainGapDone = mainAge >= CNT_W'(GAP_MAIN);
  assign clkGapDone  = clkAge  >= CNT_W'(GAP_CLK);
  assign settleDone  = tmr     >= CNT_W'(SETTLE);
  assign waitExpired = tmr     >= CNT_W'(WAIT_TO);

  // R9
  tmr_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tmr == CNT_TOP && !ctl.clrTmr) |=> tmr == CNT_TOP);

  // R3
  main_age_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrMain |=> mainAge == '0);

endmodule

// File: rtl/slot_seq_ctrl.sv
`timescale 1ns/1ps
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter bit EARLY_TRAIN = 1'b0
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   upReq,
  input  logic   downReq,
  input  logic   cardPresent,
  input  logic   auxGood,
  input  logic   mainGood,
  input  logic   clkStable,
  input  logic   linkUp,
  input  logic   lowPwrAck,
  input  logic   powerLoss,
  input  logic   mainGapDone,
  input  logic   clkGapDone,
  input  logic   settleDone,
  input  logic   waitExpired,
  output dpCtl_t dpCtl,
  output logic   auxEn,
  output logic   mainEn,
  output logic   refClkEn,
  output logic   trainEn,
  output logic   relState,
  output logic   lowPwrReq,
  output logic   ready,
  output logic   errFlag
);
  seqState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    nxt = st;
    if (powerLoss && st != S_IDLE && st != S_ERR) nxt = S_ERR;
    else begin
      case (st)
        S_IDLE:   if (upReq && cardPresent) nxt = S_AUX;
        S_AUX:    if (auxGood) nxt = S_MAIN;     else if (waitExpired) nxt = S_ERR;
        S_MAIN:   if (mainGood) nxt = S_CLK;     else if (waitExpired) nxt = S_ERR;
        S_CLK:    if (clkStable) nxt = S_GAP;    else if (waitExpired) nxt = S_ERR;
        S_GAP:    if (mainGapDone && clkGapDone) nxt = S_LINK;
        S_LINK:   if (linkUp) nxt = S_SETTLE;    else if (waitExpired) nxt = S_ERR;
        S_SETTLE: if (settleDone) nxt = S_READY;
        S_READY:  if (downReq) nxt = S_LPWAIT;
        S_LPWAIT: if (lowPwrAck) nxt = S_DNRST;  else if (waitExpired) nxt = S_ERR;
        S_DNRST:  nxt = S_DNMAIN;
        S_DNMAIN: nxt = S_DNCLK;
        S_DNCLK:  nxt = S_IDLE;
        S_ERR:    if (upReq) nxt = cardPresent ? S_AUX : S_IDLE;
        default:  nxt = S_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.clrTmr  = (nxt != st);
    dpCtl.clrMain = (st == S_MAIN) && (nxt == S_CLK);
    dpCtl.clrClk  = (st == S_CLK)  && (nxt == S_GAP);
  end

  logic lateTrain, earlyTrain;
  assign auxEn      = (st != S_IDLE) && (st != S_ERR);
  assign mainEn     = st inside {S_MAIN, S_CLK, S_GAP, S_LINK, S_SETTLE, S_READY, S_LPWAIT, S_DNRST};
  assign refClkEn   = st inside {S_CLK, S_GAP, S_LINK, S_SETTLE, S_READY, S_LPWAIT, S_DNRST, S_DNMAIN};
  assign relState   = st inside {S_LINK, S_SETTLE, S_READY, S_LPWAIT};
  assign lateTrain  = st inside {S_GAP, S_LINK, S_SETTLE, S_READY, S_LPWAIT};
  assign earlyTrain = lateTrain || (st inside {S_AUX, S_MAIN, S_CLK});
  assign trainEn    = EARLY_TRAIN ? earlyTrain : lateTrain;
  assign lowPwrReq  = (st == S_LPWAIT);
  assign ready      = (st == S_READY);
  assign errFlag    = (st == S_ERR);

  // R2
  main_after_aux_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainEn) |-> $past(auxGood) && auxEn);

  // R2
  clk_after_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refClkEn) |-> $past(mainGood) && mainEn);

  // R10
  no_card_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!auxEn && !errFlag && !cardPresent) |=> !auxEn);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !upReq) |=> errFlag);

endmodule

// File: rtl/slot_power_sequencer.sv
`timescale 1ns/1ps
module slot_power_sequencer
  import slot_seq_pkg::*;
#(
  parameter int GAP_MAIN_CYC = 25_000_000,
  parameter int GAP_CLK_CYC  = 25_000,
  parameter int SETTLE_CYC   = 25_000_000,
  parameter int WAIT_TO_CYC  = 50_000_000,
  parameter bit EARLY_TRAIN  = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic upReq,
  input  logic downReq,
  input  logic cardPresent,
  input  logic auxGood,
  input  logic mainGood,
  input  logic clkStable,
  input  logic dllCapable,
  input  logic dllActive,
  input  logic vendorLinkUp,
  input  logic lowPwrAck,
  input  logic powerLoss,
  output logic auxEn,
  output logic mainEn,
  output logic refClkEn,
  output logic trainEn,
  output logic cardRstN,
  output logic lowPwrReq,
  output logic ready,
  output logic errFlag
);
  localparam int MAX_AB  = (GAP_MAIN_CYC > GAP_CLK_CYC) ? GAP_MAIN_CYC : GAP_CLK_CYC;
  localparam int MAX_CD  = (SETTLE_CYC > WAIT_TO_CYC) ? SETTLE_CYC : WAIT_TO_CYC;
  localparam int MAX_LIM = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);

  dpCtl_t dpCtl;
  logic   mainGapDone, clkGapDone, settleDone, waitExpired;
  logic   linkUp, relState;

  assign linkUp = dllCapable ? dllActive : vendorLinkUp;

  slot_seq_ctrl #(.EARLY_TRAIN(EARLY_TRAIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq),
    .cardPresent(cardPresent), .auxGood(auxGood), .mainGood(mainGood),
    .clkStable(clkStable), .linkUp(linkUp), .lowPwrAck(lowPwrAck),
    .powerLoss(powerLoss), .mainGapDone(mainGapDone), .clkGapDone(clkGapDone),
    .settleDone(settleDone), .waitExpired(waitExpired), .dpCtl(dpCtl),
    .auxEn(auxEn), .mainEn(mainEn), .refClkEn(refClkEn), .trainEn(trainEn),
    .relState(relState), .lowPwrReq(lowPwrReq), .ready(ready), .errFlag(errFlag)
  );

  slot_seq_timers #(
    .CNT_W(CNT_W), .GAP_MAIN(GAP_MAIN_CYC), .GAP_CLK(GAP_CLK_CYC),
    .SETTLE(SETTLE_CYC), .WAIT_TO(WAIT_TO_CYC)
  ) u_timers (
    .clk(clk), .rstN(rstN), .ctl(dpCtl),
    .mainGapDone(mainGapDone), .clkGapDone(clkGapDone),
    .settleDone(settleDone), .waitExpired(waitExpired)
  );

  // surprise power loss bypasses every register
  assign cardRstN = relState && !powerLoss;

  // R3 R4
  release_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardRstN) |-> $past(mainGapDone && clkGapDone));

  // R1 R5
  release_enables_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardRstN |-> auxEn && mainEn && refClkEn && trainEn);

  // R6
  ready_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(settleDone) && cardRstN);

  // R7
  main_off_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mainEn) && !errFlag) |-> !cardRstN && $past(!cardRstN));

  // R7
  clk_off_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(refClkEn) && !errFlag) |-> $past(!mainEn));

  // R8
  loss_to_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powerLoss && ready) |=> errFlag && !mainEn);

endmodule

// File: tb/slot_power_sequencer_test.sv
`timescale 1ns/1ps
module slot_power_sequencer_test;
  localparam int GAP_MAIN = 40;
  localparam int GAP_CLK  = 12;
  localparam int SETTLE   = 30;
  localparam int WAIT_TO  = 60;
  localparam bit EARLY    = 1'b1;

  logic clk = 1'b0, rstN = 1'b0;
  logic upReq = 0, downReq = 0, cardPresent = 0, auxGood = 0, mainGood = 0, clkStable = 0;
  logic dllCapable = 0, dllActive = 0, vendorLinkUp = 0, lowPwrAck = 0, powerLoss = 0;
  logic auxEn, mainEn, refClkEn, trainEn, cardRstN, lowPwrReq, ready, errFlag;

  always #2 clk = ~clk;

  slot_power_sequencer #(
    .GAP_MAIN_CYC(GAP_MAIN), .GAP_CLK_CYC(GAP_CLK), .SETTLE_CYC(SETTLE),
    .WAIT_TO_CYC(WAIT_TO), .EARLY_TRAIN(EARLY)
  ) uut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq), .cardPresent(cardPresent),
    .auxGood(auxGood), .mainGood(mainGood), .clkStable(clkStable), .dllCapable(dllCapable),
    .dllActive(dllActive), .vendorLinkUp(vendorLinkUp), .lowPwrAck(lowPwrAck),
    .powerLoss(powerLoss), .auxEn(auxEn), .mainEn(mainEn), .refClkEn(refClkEn),
    .trainEn(trainEn), .cardRstN(cardRstN), .lowPwrReq(lowPwrReq), .ready(ready),
    .errFlag(errFlag)
  );

  int nTests = 0, nFail = 0, cyc = 0;
  bit done = 0;
  int auxLat = 2, mainLat = 2, clkLat = 2, linkLat = 2, ackLat = 2;
  int auxCnt = 0, mainCnt = 0, clkCnt = 0, linkCnt = 0, ackCnt = 0;
  int tMainG = 0, tClkG = 0, tLink = 0;
  logic pAux = 0, pMain = 0, pClk = 0, pRst = 0, pReady = 0, pLink = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected link source per R6
  function automatic logic expLink(input logic cap, input logic dll, input logic ven);
    return cap ? dll : ven;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor first, then card/board model, all at the falling edge
  always @(negedge clk) begin
    logic lk;
    if (rstN) begin
      if (auxEn && !pAux) chk(trainEn == EARLY, "R5 train enable timing", trainEn, EARLY);
      if (mainEn && !pMain) chk(auxGood && pAux, "R2 main after aux good", auxGood, 1);
      if (refClkEn && !pClk) chk(mainGood && pMain, "R2 clock after main good", mainGood, 1);
      if (cardRstN && !pRst) begin
        chk(auxEn && mainEn && refClkEn, "R1 release with all enables", {auxEn, mainEn, refClkEn}, 7);
        chk(cyc - tMainG >= GAP_MAIN, "R3 main gap", cyc - tMainG, GAP_MAIN);
        chk(cyc - tClkG >= GAP_CLK, "R4 clock gap", cyc - tClkG, GAP_CLK);
        chk(trainEn, "R5 training before release", trainEn, 1);
      end
      if (cardRstN && !(mainEn && refClkEn)) chk(0, "R1 reset held while off", cardRstN, 0);
      lk = expLink(dllCapable, dllActive, vendorLinkUp);
      if (lk && !pLink) tLink = cyc;
      pLink = lk;
      if (ready && !pReady) chk(cyc - tLink >= SETTLE, "R6 settle after link", cyc - tLink, SETTLE);
      if (!mainEn && pMain && !errFlag) chk(!pRst, "R7 reset before main off", pRst, 0);
      if (!refClkEn && pClk && !errFlag) chk(!pMain, "R7 main off before clock off", pMain, 0);
    end
    pAux = auxEn; pMain = mainEn; pClk = refClkEn; pRst = cardRstN; pReady = ready;
    // model
    auxCnt  = auxEn ? auxCnt + 1 : 0;
    mainCnt = mainEn ? mainCnt + 1 : 0;
    clkCnt  = refClkEn ? clkCnt + 1 : 0;
    linkCnt = cardRstN ? linkCnt + 1 : 0;
    ackCnt  = lowPwrReq ? ackCnt + 1 : 0;
    auxGood = auxEn && auxCnt > auxLat;
    if (mainEn && mainCnt > mainLat && !mainGood) tMainG = cyc;
    mainGood = mainEn && mainCnt > mainLat;
    if (refClkEn && clkCnt > clkLat && !clkStable) tClkG = cyc;
    clkStable = refClkEn && clkCnt > clkLat;
    lowPwrAck = lowPwrReq && ackCnt > ackLat;
    // the ignored source is a decoy held high
    if (dllCapable) begin
      vendorLinkUp = cardPresent;
      dllActive = cardRstN && linkCnt > linkLat;
    end else begin
      dllActive = cardPresent;
      vendorLinkUp = cardRstN && linkCnt > linkLat;
    end
  end

  task automatic pulseUp();
    @(negedge clk) upReq = 1'b1;
    @(negedge clk) upReq = 1'b0;
  endtask

  task automatic waitReady(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      if (ready) begin ok = 1'b1; break; end
    end
  endtask

  task automatic waitIdle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!auxEn) begin ok = 1'b1; break; end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    bit ok;
    void'($urandom(32'd20211108));
    repeat (4) @(negedge clk);
    chk(!auxEn && !mainEn && !refClkEn && !cardRstN && !ready && !errFlag,
        "R1 reset state", {auxEn, mainEn, refClkEn, cardRstN}, 0);
    rstN = 1'b1;

    // R10: no card present
    pulseUp();
    repeat (20) @(negedge clk);
    chk(!auxEn && !cardRstN && !errFlag, "R10 no card stays idle", auxEn, 0);
    cardPresent = 1'b1;

    // random bring-up / power-down runs
    for (int k = 0; k < 8; k++) begin
      auxLat  = $urandom_range(0, 10);
      mainLat = $urandom_range(0, 10);
      clkLat  = (k % 3 == 0) ? $urandom_range(30, 45) : $urandom_range(0, 8);
      linkLat = $urandom_range(0, 20);
      ackLat  = $urandom_range(0, 6);
      dllCapable = k[0];
      pulseUp();
      waitReady(ok);
      chk(ok, "R6 ready reached", ok, 1);
      repeat ($urandom_range(1, 10)) @(negedge clk);
      chk(ready && cardRstN, "R6 ready holds", ready, 1);
      @(negedge clk) downReq = 1'b1;
      @(negedge clk) downReq = 1'b0;
      waitIdle(ok);
      chk(ok && !mainEn && !refClkEn && !cardRstN && !errFlag, "R7 power-down completes",
          {mainEn, refClkEn, cardRstN, errFlag}, 0);
    end

    // R9: main supply never good
    mainLat = 1000;
    pulseUp();
    repeat (WAIT_TO + 10) @(negedge clk);
    chk(errFlag && !auxEn && !mainEn && !cardRstN, "R9 timeout to error", errFlag, 1);
    repeat (30) @(negedge clk);
    chk(errFlag && !cardRstN, "R9 error sticky", errFlag, 1);
    mainLat = 3;
    pulseUp();
    chk(!errFlag && auxEn, "R9 new request clears error", errFlag, 0);
    waitReady(ok);
    chk(ok, "R9 recovery reaches ready", ok, 1);

    // R8: surprise power loss between edges
    @(negedge clk) #1 powerLoss = 1'b1;
    #0.5 chk(!cardRstN, "R8 reset low without clock edge", cardRstN, 0);
    @(negedge clk);
    chk(errFlag && !mainEn && !refClkEn && !cardRstN, "R8 power loss to error", errFlag, 1);
    powerLoss = 1'b0;
    repeat (3) @(negedge clk);
    chk(errFlag && !cardRstN, "R8 error holds after loss clears", errFlag, 1);

    // R10: request from error with no card goes idle
    cardPresent = 1'b0;
    pulseUp();
    repeat (5) @(negedge clk);
    chk(!errFlag && !auxEn && !cardRstN, "R10 error to idle without card", errFlag, 0);
    cardPresent = 1'b1;

    // R9: low-power acknowledge never arrives
    ackLat = 1000;
    pulseUp();
    waitReady(ok);
    chk(ok, "R6 ready before ack timeout run", ok, 1);
    @(negedge clk) downReq = 1'b1;
    @(negedge clk) downReq = 1'b0;
    repeat (WAIT_TO + 10) @(negedge clk);
    chk(errFlag && !cardRstN && !mainEn, "R9 ack timeout to error", errFlag, 1);

    summary();
  end
endmodule